// File: doc/BRIEF.md
# Free-Running Timer with Buffered Input Capture

This block is a timer peripheral built around a 16-bit up-counter that advances on each clock-enable tick. Two compare registers are watched against the counter, and a match on the first one can reset the counter to zero, which turns the counter into a periodic timebase. Two capture channels copy the counter value when their event input pulses. Each channel has a companion register. That register either takes direct captures of its own, or acts as a buffer that keeps the previous capture value when a new one arrives.

Seven sticky event flags and the clear-on-match enable share one 8-bit status/control word. Only hardware can set a flag. Software can lower a flag only after it has seen that flag as 1 in a read of the status word. All registers sit on a simple synchronous bus. A write takes effect at the clock edge on which it is presented. Read data is combinational from the address. The capture event inputs are single-cycle pulses that are already synchronous to the clock.

Top module: `frt_core`

## Requirements
- R1: On a clock edge with `rst` high, the counter, the compare, capture and mode registers and the status word (including the clear-on-match enable) all become zero.
- R2: Register map on `bus_addr`: 0 counter (read/write), 1 compare A, 2 compare B, 3 capture A, 4 capture B, 5 capture C, 6 capture D (3 to 6 read-only), 7 status/control (8 bits, zero-extended on read), 8 buffer mode (bit 0 = channel A, bit 1 = channel B). A read is `bus_sel`=1 with `bus_wr`=0. Unmapped addresses read as zero.
- R3: The counter increases by 1 on each edge where `tick`=1 and holds its value when `tick`=0. A bus write to address 0 loads the counter and takes priority over the tick.
- R4: When a tick advances the counter from 0xFFFF to 0x0000, the overflow flag (status bit 1) is set.
- R5: On a tick edge where the counter equals compare A, status bit 3 is set. On a tick edge where the counter equals compare B, status bit 2 is set.
- R6: While status bit 0 is 1, a tick edge on which the counter equals compare A loads zero into the counter instead of incrementing it.
- R7: With buffering off, a pulse on `cap_in[0]` (channel A) or `cap_in[1]` (channel B) copies the present counter value into capture A or capture B, and sets status bit 7 or status bit 6 respectively.
- R8: With buffering on for a channel, its capture pulse moves the old capture A (or B) value into capture C (or D) and loads the counter into capture A (or B). The flag set is bit 7 (or bit 6) only.
- R9: With buffering off for a channel, a pulse on `cap_in[2]` (or `cap_in[3]`) copies the counter into capture C (or D) and sets status bit 5 (or 4). With buffering on, that input is ignored.
- R10: Writing 1 to status bits 7 to 1 has no effect. Status bit 0 reads back what was last written to it.
- R11: A status write of 0 to a flag clears that flag only if a read of the status word since the last status write returned that flag as 1. Any status write cancels all such prior reads. Otherwise the flag stays set.
- R12: If a hardware set and a software clear hit the same flag on the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock-enable |
| cap_in | input | 4 | Capture event pulses: bit 0 A, bit 1 B, bit 2 C, bit 3 D |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |

## Verification
The capture path is driven by a table of steps. Each step holds the counter at a new known value and pulses a different mix of capture inputs under a different buffer mode. This separates direct loads from buffer shifts, and shows whether a companion input is honoured or ignored while its channel buffers. Counter tests compare runs with the tick held low and runs with it pulsing. They also compare runs with clear-on-match enabled and disabled across the same compare value, and include a wrap from the top count. Flag tests use writes of zero with and without a prior read, a clear of a single flag inside a multi-flag word, and a clear that lands on the same edge as a capture.

// File: rtl/frt_pkg.sv
package frt_pkg;

    localparam int ADDR_W = 4;
    localparam int STAT_W = 8;
    localparam int NFLAG  = STAT_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_COUNT = 4'd0,
        RA_CMPA  = 4'd1,
        RA_CMPB  = 4'd2,
        RA_CAPA  = 4'd3,
        RA_CAPB  = 4'd4,
        RA_CAPC  = 4'd5,
        RA_CAPD  = 4'd6,
        RA_STAT  = 4'd7,
        RA_MODE  = 4'd8
    } reg_addr_e;

    // Packed MSB first: the fields line up with status bits 7 down to 1.
    typedef struct packed {
        logic cap_a;
        logic cap_b;
        logic cap_c;
        logic cap_d;
        logic cmp_a;
        logic cmp_b;
        logic ovf;
    } flag_set_t;

    typedef struct packed {
        logic ovf;
        logic cmp_a;
        logic cmp_b;
    } cnt_evt_t;

    function automatic flag_set_t build_flags(input logic [1:0] main_set,
                                              input logic [1:0] aux_set,
                                              input cnt_evt_t   evt);
        flag_set_t f;
        f.cap_a = main_set[0];
        f.cap_b = main_set[1];
        f.cap_c = aux_set[0];
        f.cap_d = aux_set[1];
        f.cmp_a = evt.cmp_a;
        f.cmp_b = evt.cmp_b;
        f.ovf   = evt.ovf;
        return f;
    endfunction

endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [W-1:0]      load_val,
    input  logic              clr_en,
    input  logic [W-1:0]      cmp_a,
    input  logic [W-1:0]      cmp_b,
    output logic [W-1:0]      cnt,
    output frt_pkg::cnt_evt_t evt
);
    localparam logic [W-1:0] TOP = '1;

    logic match_a, match_b, clear;

    assign match_a = (cnt == cmp_a);
    assign match_b = (cnt == cmp_b);
    assign clear   = tick && clr_en && match_a;

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (clear) cnt <= '0;
        else if (tick)  cnt <= cnt + 1'b1;
    end

    always_comb begin
        evt.ovf   = tick && !load && !clear && (cnt == TOP);
        evt.cmp_a = tick && match_a;
        evt.cmp_b = tick && match_b;
    end

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(cnt));
    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && !clr_en && cnt == TOP) |=> (cnt == '0));
    assert_clear_on_match_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && clr_en && cnt == cmp_a) |=> (cnt == '0));

endmodule

// File: rtl/frt_capture_pair.sv
module frt_capture_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         buf_en,
    input  logic         ev_main,
    input  logic         ev_aux,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] main_q,
    output logic [W-1:0] aux_q,
    output logic         set_main,
    output logic         set_aux
);
    assign set_main = ev_main;
    assign set_aux  = ev_aux && !buf_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= '0;
            aux_q  <= '0;
        end else begin
            if (ev_main) main_q <= cnt;
            if (ev_main && buf_en)      aux_q <= main_q;
            else if (ev_aux && !buf_en) aux_q <= cnt;
        end
    end

    assert_direct_load_R7: assert property (@(posedge clk) disable iff (rst)
        ev_main |=> (main_q == $past(cnt)));
    assert_buffer_shift_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_main && buf_en) |=> (aux_q == $past(main_q)));
    assert_aux_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (buf_en && !ev_main) |=> $stable(aux_q));

endmodule

// File: rtl/frt_status.sv
module frt_status
    import frt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flag_set_t         set_i,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] stat,
    output logic              clr_en
);
    logic [NFLAG-1:0] flags, armed, hw_set, sw_clr;

    assign hw_set = set_i;
    assign sw_clr = wr_stb ? (armed & ~wdata[STAT_W-1:1]) : '0;
    assign stat   = {flags, clr_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            armed  <= '0;
            clr_en <= 1'b0;
        end else begin
            flags <= hw_set | (flags & ~sw_clr);
            if (wr_stb) begin
                armed  <= '0;
                clr_en <= wdata[0];
            end else if (rd_stb) begin
                armed  <= armed | flags;
            end
        end
    end

    assert_hw_only_sets_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(hw_set)) == '0));
    assert_clear_needs_read_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~flags & $past(flags) & ~$past(armed)) == '0));
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(hw_set) & ~flags) == '0));

endmodule

// File: rtl/frt_core.sv
module frt_core
    import frt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [3:0]        cap_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata
);
    localparam int NCH = 2;

    logic [W-1:0]      cmp_a, cmp_b, cnt;
    logic [NCH-1:0]    buf_mode;
    logic [W-1:0]      main_q [NCH];
    logic [W-1:0]      aux_q  [NCH];
    logic [NCH-1:0]    set_main, set_aux;
    logic              wr_any, rd_any, clr_en;
    logic [STAT_W-1:0] stat;
    cnt_evt_t          evt;
    flag_set_t         flag_set;

    assign wr_any = bus_sel && bus_wr;
    assign rd_any = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a    <= '0;
            cmp_b    <= '0;
            buf_mode <= '0;
        end else if (wr_any) begin
            case (bus_addr)
                RA_CMPA: cmp_a    <= bus_wdata;
                RA_CMPB: cmp_b    <= bus_wdata;
                RA_MODE: buf_mode <= bus_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    frt_counter #(.W(W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (wr_any && bus_addr == RA_COUNT),
        .load_val (bus_wdata),
        .clr_en   (clr_en),
        .cmp_a    (cmp_a),
        .cmp_b    (cmp_b),
        .cnt      (cnt),
        .evt      (evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        frt_capture_pair #(.W(W)) u_cap (
            .clk      (clk),
            .rst      (rst),
            .buf_en   (buf_mode[g]),
            .ev_main  (cap_in[g]),
            .ev_aux   (cap_in[g+NCH]),
            .cnt      (cnt),
            .main_q   (main_q[g]),
            .aux_q    (aux_q[g]),
            .set_main (set_main[g]),
            .set_aux  (set_aux[g])
        );
    end

    assign flag_set = build_flags(set_main, set_aux, evt);

    frt_status u_status (
        .clk    (clk),
        .rst    (rst),
        .set_i  (flag_set),
        .rd_stb (rd_any && bus_addr == RA_STAT),
        .wr_stb (wr_any && bus_addr == RA_STAT),
        .wdata  (bus_wdata[STAT_W-1:0]),
        .stat   (stat),
        .clr_en (clr_en)
    );

    always_comb begin
        case (bus_addr)
            RA_COUNT: bus_rdata = cnt;
            RA_CMPA:  bus_rdata = cmp_a;
            RA_CMPB:  bus_rdata = cmp_b;
            RA_CAPA:  bus_rdata = main_q[0];
            RA_CAPB:  bus_rdata = main_q[1];
            RA_CAPC:  bus_rdata = aux_q[0];
            RA_CAPD:  bus_rdata = aux_q[1];
            RA_STAT:  bus_rdata = W'(stat);
            RA_MODE:  bus_rdata = W'(buf_mode);
            default:  bus_rdata = '0;
        endcase
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (stat == '0 && cnt == '0 && buf_mode == '0));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_any && !clr_en && cnt != '1) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: tb/frt_core_bench.sv
`timescale 1ns/1ps
module frt_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frt_core u_frt_core (
        .clk(clk), .rst(rst), .tick(tick), .cap_in(cap_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [3:0]  pulse;
        logic [15:0] preset;
        logic [15:0] exp_a;
        logic [15:0] exp_b;
        logic [15:0] exp_c;
        logic [15:0] exp_d;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'b00, 4'b0001, 16'h1111, 16'h1111, 16'h0000, 16'h0000, 16'h0000},
        '{2'b01, 4'b0001, 16'h2222, 16'h2222, 16'h0000, 16'h1111, 16'h0000},
        '{2'b01, 4'b0101, 16'h3333, 16'h3333, 16'h0000, 16'h2222, 16'h0000},
        '{2'b00, 4'b0100, 16'h4444, 16'h3333, 16'h0000, 16'h4444, 16'h0000},
        '{2'b10, 4'b0010, 16'h5555, 16'h3333, 16'h5555, 16'h4444, 16'h0000},
        '{2'b10, 4'b0010, 16'h6666, 16'h3333, 16'h6666, 16'h4444, 16'h5555},
        '{2'b00, 4'b1010, 16'h7777, 16'h3333, 16'h7777, 16'h4444, 16'h7777},
        '{2'b11, 4'b0011, 16'h8888, 16'h8888, 16'h8888, 16'h3333, 16'h7777}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        cap_in = m;
        @(negedge clk);
        cap_in = '0;
    endtask

    task automatic clear_flags(input logic keep_clr);
        logic [15:0] tmp;
        rd(4'd7, tmp);
        wr(4'd7, {15'd0, keep_clr});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(4'd7, v); chk("R1 status", v, 16'h0000);
        rd(4'd0, v); chk("R1 counter", v, 16'h0000);
        rd(4'd3, v); chk("R1 capA", v, 16'h0000);

        // R10: hardware-only bits ignore writes of 1, bit 0 is read/write
        wr(4'd7, 16'h00FF);
        rd(4'd7, v); chk("R10 write ones", v, 16'h0001);
        wr(4'd7, 16'h0000);
        rd(4'd7, v); chk("R10 bit0 back", v, 16'h0000);

        // R2: map and unmapped address
        wr(4'd2, 16'hBEEF);
        rd(4'd2, v); chk("R2 cmpB readback", v, 16'hBEEF);
        rd(4'd12, v); chk("R2 unmapped", v, 16'h0000);
        wr(4'd2, 16'h0000);

        // R7 R8 R9: capture table
        foreach (VECS[i]) begin
            wr(4'd8, {14'd0, VECS[i].mode});
            wr(4'd0, VECS[i].preset);
            pulse(VECS[i].pulse);
            rd(4'd3, v); chk($sformatf("R7/R8 capA vec %0d", i), v, VECS[i].exp_a);
            rd(4'd4, v); chk($sformatf("R7/R8 capB vec %0d", i), v, VECS[i].exp_b);
            rd(4'd5, v); chk($sformatf("R8/R9 capC vec %0d", i), v, VECS[i].exp_c);
            rd(4'd6, v); chk($sformatf("R8/R9 capD vec %0d", i), v, VECS[i].exp_d);
        end
        wr(4'd8, 16'h0000);

        // R11: a write of 0 without a prior read leaves flags set
        wr(4'd7, 16'h0000);
        rd(4'd7, v); chk("R11 no prior read", v, 16'h00F0);
        // read arms all; clearing only bit 7
        wr(4'd7, 16'h0070);
        rd(4'd7, v); chk("R11 single clear", v, 16'h0070);
        wr(4'd7, 16'h0000);
        rd(4'd7, v); chk("R11 full clear", v, 16'h0000);

        // R12: hardware set and software clear on the same edge
        pulse(4'b0001);
        rd(4'd7, v); chk("R12 flag up", v, 16'h0080);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd7; bus_wdata = 16'h0000; cap_in = 4'b0001;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; cap_in = '0;
        rd(4'd7, v); chk("R12 set wins", v, 16'h0080);
        clear_flags(1'b0);
        rd(4'd7, v); chk("R11 cleared after set-wins", v, 16'h0000);

        // R3: hold without tick, count with tick, load
        wr(4'd0, 16'h0100);
        repeat (3) @(negedge clk);
        rd(4'd0, v); chk("R3 hold", v, 16'h0100);
        ticks(5);
        rd(4'd0, v); chk("R3 count", v, 16'h0105);

        // R4: wrap sets overflow
        wr(4'd0, 16'hFFFE);
        ticks(2);
        rd(4'd0, v); chk("R4 wrapped", v, 16'h0000);
        rd(4'd7, v); chk("R4 overflow flag", v, 16'h0002);
        clear_flags(1'b0);

        // R5: compare B
        wr(4'd2, 16'h000F);
        wr(4'd0, 16'h000E);
        ticks(1);
        rd(4'd7, v); chk("R5 no match yet", v, 16'h0000);
        ticks(1);
        rd(4'd7, v); chk("R5 cmpB flag", v, 16'h0004);
        rd(4'd0, v); chk("R5 counter", v, 16'h0010);
        clear_flags(1'b0);

        // R5 R6: compare A without clear-on-match
        wr(4'd1, 16'h0020);
        wr(4'd0, 16'h001F);
        ticks(2);
        rd(4'd0, v); chk("R6 no clear when off", v, 16'h0021);
        rd(4'd7, v); chk("R5 cmpA flag", v, 16'h0008);
        clear_flags(1'b1);

        // R6: with clear-on-match
        wr(4'd0, 16'h001F);
        ticks(2);
        rd(4'd0, v); chk("R6 cleared on match", v, 16'h0000);
        rd(4'd7, v); chk("R6 flag and enable", v, 16'h0009);
        ticks(3);
        rd(4'd0, v); chk("R6 restarts", v, 16'h0003);

        finish_run();
    end

endmodule